// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block gathers single-cycle event strobes from a set of DMA channels into one sticky status word per channel. Software clears the status with write-one-to-clear writes. Each channel forms two derived summary bits. The normal summary covers completion-type events and the abnormal summary covers error-type events. A per-channel enable word masks the individual events and gates each summary onto the interrupt. The channel requests are OR-ed into a single interrupt line.

A read-only top-level word reports which channels are requesting service, together with two external requests: one from the queue layer and one from the MAC. A parameter selects one of two positions for the summary enable bits. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `dmairq_unit`

## Requirements
- R1: After reset, every status word reads 0 and `irq_o` is low. Each enable word reads its default. With LAYOUT=0 the default is 0x0001_9041 (bits 16, 15, 12, 6, 0). With LAYOUT=1 the default is 0x0000_D041 (bits 15, 14, 12, 6, 0).
- R2: Event index i of a channel (vector `evt_i[ch*11+i]`) sets status bit i for i<3 and bit i+3 for i≥3. Index 0 is transmit done, 1 transmit stopped, 2 transmit buffer unavailable, 3 receive done, 4 receive buffer unavailable, 5 receive stopped, 6 receive watchdog, 7 early transmit, 8 early receive, 9 fatal bus error and 10 context error. A set bit is readable one clock after the strobe and stays set until cleared.
- R3: A status write clears each bit where the written data has a 1, over the mask 0x3FFFC7, and leaves bits written with 0 unchanged. Bits 5:3 always read 0. Bits 15:14 are derived and are never stored.
- R4: If an event strobe and a clearing write to the same bit happen in the same cycle, the bit is set afterwards.
- R5: Status bit 15 (normal summary) reads 1 exactly when any of status bits 0, 2, 6 or 11 is set together with the same enable bit.
- R6: Status bit 14 (abnormal summary) reads 1 exactly when any of status bits 1, 7, 8, 9, 10, 12 or 13 is set together with the same enable bit.
- R7: `irq_o` is high while some channel has its normal summary with the normal enable set, or its abnormal summary with the abnormal enable set. With LAYOUT=0 the normal enable is bit 16 and the abnormal enable is bit 15. With LAYOUT=1 they are bits 15 and 14.
- R8: A fatal bus error strobe ORs `tx_code_i` of that channel into status bits 18:16 and `rx_code_i` into bits 21:19. Those bits clear on a write of ones.
- R9: The top-level word (register select 2) shows channel c's request in bit c, `queue_irq_i` in bit 16 and `mac_irq_i` in bit 17. All other bits read 0.
- R10: Only the event bits (mask 0x3FC7) and the two summary enable bits of the enable word are writable. All other enable bits read 0.
- R11: Clearing every underlying status bit also clears both summaries and drops `irq_o` on the next read.
- R12: A write reaches only the channel in the upper address bits. Address bits 1:0 select the register: 0 status, 1 enable, 2 top-level word, 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_CH*11 | Event strobes, 11 per channel |
| tx_code_i | input | NUM_CH*3 | Transmit error code per channel, sampled on fatal bus error |
| rx_code_i | input | NUM_CH*3 | Receive error code per channel, sampled on fatal bus error |
| queue_irq_i | input | 1 | Queue-layer interrupt request |
| mac_irq_i | input | 1 | MAC interrupt request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | CH_W+2 | {channel, register select} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that event strobes last a single cycle. They also assume that the register port is quiet whenever the status is expected to hold. The stability check only claims that status holds in cycles with no write and no strobe. The bench drives every strobe and write for one cycle from the falling edge and holds all inputs at 0 between scenarios. The queue and MAC requests are treated as levels that may change at any time, and the top-word check compares against their present value.

// File: rtl/dmairq_pkg.sv
// Shared constants and helpers for the DMA channel interrupt status unit.
// Assumes a 32-bit register port and eleven event sources per channel.
package dmairq_pkg;
    localparam int EVT_N       = 11;
    localparam int REG_W       = 32;
    localparam int CODE_W      = 3;
    localparam int FATAL_IDX   = 9;
    localparam int NSUM_BIT    = 15;
    localparam int ASUM_BIT    = 14;
    localparam int TXCODE_LSB  = 16;
    localparam int RXCODE_LSB  = 19;

    localparam logic [REG_W-1:0] EVT_BITS   = 32'h0000_3FC7;
    localparam logic [REG_W-1:0] CLR_MASK   = 32'h003F_FFC7;
    localparam logic [REG_W-1:0] STORE_MASK = 32'h003F_3FC7;
    localparam logic [REG_W-1:0] NORM_SRC   = 32'h0000_0845;
    localparam logic [REG_W-1:0] ABN_SRC    = 32'h0000_3782;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_EN   = 2'd1,
        SEL_TOP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Status bit position of compact event index idx (hole at 5:3).
    function automatic int evt_pos(input int idx);
        return (idx < 3) ? idx : idx + 3;
    endfunction

    // Normal summary enable position for the chosen layout.
    function automatic int nie_pos(input int layout);
        return (layout == 0) ? 16 : 15;
    endfunction

    // Abnormal summary enable position for the chosen layout.
    function automatic int aie_pos(input int layout);
        return (layout == 0) ? 15 : 14;
    endfunction

    // Reset value of the enable word.
    function automatic logic [REG_W-1:0] en_default(input int layout);
        logic [REG_W-1:0] v;
        v = 32'h0000_1041;
        v[nie_pos(layout)] = 1'b1;
        v[aie_pos(layout)] = 1'b1;
        return v;
    endfunction

    // Writable bits of the enable word.
    function automatic logic [REG_W-1:0] en_wmask(input int layout);
        logic [REG_W-1:0] v;
        v = EVT_BITS;
        v[nie_pos(layout)] = 1'b1;
        v[aie_pos(layout)] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dmairq_status_reg.sv
// Sticky per-channel status storage with write-one-to-clear.
// Assumes event strobes are one cycle wide; a strobe overrides a clear.
module dmairq_status_reg
    import dmairq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_N-1:0]     evt_i,
    input  logic [CODE_W-1:0]    tx_code_i,
    input  logic [CODE_W-1:0]    rx_code_i,
    input  logic                 clr_i,
    input  logic [REG_W-1:0]     clr_data_i,
    output logic [REG_W-1:0]     stat_o
);
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    // Map compact event strobes and error codes onto status positions.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < EVT_N; i++) begin
            set_vec[evt_pos(i)] = evt_i[i];
        end
        if (evt_i[FATAL_IDX]) begin
            set_vec[TXCODE_LSB +: CODE_W] = tx_code_i;
            set_vec[RXCODE_LSB +: CODE_W] = rx_code_i;
        end
    end

    // Bits a status write removes this cycle.
    always_comb begin
        clr_vec = clr_i ? (clr_data_i & CLR_MASK) : '0;
    end

    // Status register update: clear first, then set, so events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & STORE_MASK;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/dmairq_enable_reg.sv
// Per-channel interrupt enable word; LAYOUT picks the summary enable positions.
// Assumes full-word writes; non-writable bits read back as 0.
module dmairq_enable_reg
    import dmairq_pkg::*;
#(
    parameter int LAYOUT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] en_o
);
    localparam logic [REG_W-1:0] WMASK = en_wmask(LAYOUT);
    localparam logic [REG_W-1:0] RVAL  = en_default(LAYOUT);

    logic [REG_W-1:0] en_q;

    // Enable register load with writable-bit masking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= RVAL;
        end else if (wr_i) begin
            en_q <= wr_data_i & WMASK;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/dmairq_irq_eval.sv
// Derives the normal and abnormal summaries and the channel request.
// Assumes stat_i never holds summary bits of its own (they are masked on store).
module dmairq_irq_eval
    import dmairq_pkg::*;
#(
    parameter int LAYOUT = 0
) (
    input  logic [REG_W-1:0] stat_i,
    input  logic [REG_W-1:0] en_i,
    output logic [REG_W-1:0] view_o,
    output logic             req_o
);
    localparam int NIE = nie_pos(LAYOUT);
    localparam int AIE = aie_pos(LAYOUT);

    logic norm_sum;
    logic abn_sum;

    // Summaries: OR of enabled sources in each class.
    always_comb begin
        norm_sum = |(stat_i & en_i & NORM_SRC);
        abn_sum  = |(stat_i & en_i & ABN_SRC);
    end

    // Readable status with the derived summary bits inserted.
    always_comb begin
        view_o           = stat_i;
        view_o[NSUM_BIT] = norm_sum;
        view_o[ASUM_BIT] = abn_sum;
    end

    // Channel request gated by the summary enables.
    always_comb begin
        req_o = (norm_sum & en_i[NIE]) | (abn_sum & en_i[AIE]);
    end
endmodule

// File: rtl/dmairq_unit.sv
// Top of the DMA channel interrupt status unit: NUM_CH channels, register
// decode, top-level request word and the combined interrupt line.
// Assumes 1 <= NUM_CH <= 8 and a single-cycle write strobe.
module dmairq_unit
    import dmairq_pkg::*;
#(
    parameter int  NUM_CH = 2,
    parameter int  LAYOUT = 0,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW     = CH_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*EVT_N-1:0]  evt_i,
    input  logic [NUM_CH*CODE_W-1:0] tx_code_i,
    input  logic [NUM_CH*CODE_W-1:0] rx_code_i,
    input  logic                     queue_irq_i,
    input  logic                     mac_irq_i,
    input  logic                     reg_wr_i,
    input  logic [AW-1:0]            reg_addr_i,
    input  logic [REG_W-1:0]         reg_wdata_i,
    output logic [REG_W-1:0]         reg_rdata_o,
    output logic                     irq_o
);
    localparam int QUEUE_BIT = 16;
    localparam int MAC_BIT   = 17;

    logic [CH_W-1:0]         sel_ch;
    reg_sel_e                sel;
    logic [NUM_CH-1:0]       ch_req;
    logic [REG_W-1:0]        stat_q   [NUM_CH];
    logic [REG_W-1:0]        stat_vw  [NUM_CH];
    logic [REG_W-1:0]        en_q     [NUM_CH];
    logic [NUM_CH*REG_W-1:0] stat_flat;
    logic [REG_W-1:0]        top_word;

    assign sel_ch = reg_addr_i[AW-1:2];
    assign sel    = reg_sel_e'(reg_addr_i[1:0]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = reg_wr_i && (sel_ch == CH_W'(c));

        dmairq_status_reg u_stat (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[c*EVT_N +: EVT_N]),
            .tx_code_i  (tx_code_i[c*CODE_W +: CODE_W]),
            .rx_code_i  (rx_code_i[c*CODE_W +: CODE_W]),
            .clr_i      (hit && (sel == SEL_STAT)),
            .clr_data_i (reg_wdata_i),
            .stat_o     (stat_q[c])
        );

        dmairq_enable_reg #(.LAYOUT(LAYOUT)) u_en (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (hit && (sel == SEL_EN)),
            .wr_data_i (reg_wdata_i),
            .en_o      (en_q[c])
        );

        dmairq_irq_eval #(.LAYOUT(LAYOUT)) u_eval (
            .stat_i (stat_q[c]),
            .en_i   (en_q[c]),
            .view_o (stat_vw[c]),
            .req_o  (ch_req[c])
        );

        assign stat_flat[c*REG_W +: REG_W] = stat_q[c];
    end

    // Top-level request word: channels, queue layer, MAC.
    always_comb begin
        top_word                 = '0;
        top_word[NUM_CH-1:0]     = ch_req;
        top_word[QUEUE_BIT]      = queue_irq_i;
        top_word[MAC_BIT]        = mac_irq_i;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (sel)
            SEL_TOP:  reg_rdata_o = top_word;
            SEL_STAT: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (sel_ch == CH_W'(c)) reg_rdata_o = stat_vw[c];
                end
            end
            SEL_EN: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (sel_ch == CH_W'(c)) reg_rdata_o = en_q[c];
                end
            end
            default:  reg_rdata_o = '0;
        endcase
    end

    // Single interrupt line from all channel requests.
    assign irq_o = |ch_req;
endmodule

// File: rtl/dmairq_unit_chk.sv
// Property checker for dmairq_unit, attached with bind.
// Assumes the bench holds evt_i and reg_wr_i low when it expects status to hold.
module dmairq_unit_chk #(
    parameter int NUM_CH = 2,
    parameter int EVW    = 22,
    parameter int AW     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [EVW-1:0]      evt_i,
    input logic                reg_wr_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [31:0]         reg_rdata_o,
    input logic                queue_irq_i,
    input logic                mac_irq_i,
    input logic                irq_o,
    input logic [NUM_CH*32-1:0] stat_flat
);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && (evt_i == '0)) |=> $stable(stat_flat));

    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> stat_flat[0]);

    // R3
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i[1:0] == 2'd0) |-> (reg_rdata_o[5:3] == 3'd0));

    // R9
    top_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i[1:0] == 2'd2) |->
            (reg_rdata_o[16] == queue_irq_i && reg_rdata_o[17] == mac_irq_i));

    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flat == '0) |-> !irq_o);
endmodule

bind dmairq_unit dmairq_unit_chk #(
    .NUM_CH (NUM_CH),
    .EVW    (NUM_CH*dmairq_pkg::EVT_N),
    .AW     (AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .queue_irq_i (queue_irq_i),
    .mac_irq_i   (mac_irq_i),
    .irq_o       (irq_o),
    .stat_flat   (stat_flat)
);

// File: tb/dmairq_unit_tb_top.sv
// Directed bench for dmairq_unit: one task per scenario.
module dmairq_unit_tb_top;
    localparam int NCH = 2;
    localparam int EVN = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH*EVN-1:0] evt = '0;
    logic [NCH*3-1:0]   txc = '0;
    logic [NCH*3-1:0]   rxc = '0;
    logic          qirq = 1'b0;
    logic          mirq = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, rdata_alt;
    logic          irq, irq_alt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dmairq_unit #(.NUM_CH(NCH), .LAYOUT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .tx_code_i(txc), .rx_code_i(rxc),
        .queue_irq_i(qirq), .mac_irq_i(mirq), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    dmairq_unit #(.NUM_CH(NCH), .LAYOUT(1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .tx_code_i(txc), .rx_code_i(rxc),
        .queue_irq_i(qirq), .mac_irq_i(mirq), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata_alt), .irq_o(irq_alt));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] v, output logic [31:0] va);
        addr = {ch[0], sel[1:0]};
        #1;
        v  = rdata;
        va = rdata_alt;
    endtask

    task automatic wrr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = {ch[0], sel[1:0]}; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input int ch, input int idx);
        @(negedge clk);
        evt[ch*EVN+idx] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic clear_all();
        wrr(0, 0, 32'hFFFF_FFFF);
        wrr(1, 0, 32'hFFFF_FFFF);
    endtask

    function automatic int pos(input int idx);
        return (idx < 3) ? idx : idx + 3;
    endfunction

    task automatic t_reset();
        logic [31:0] v, va;
        rd(0, 0, v, va); chk("R1 status ch0", v, 32'h0);
        rd(1, 0, v, va); chk("R1 status ch1", v, 32'h0);
        rd(0, 1, v, va);
        chk("R1 enable layout0", v, 32'h0001_9041);
        chk("R1 enable layout1", va, 32'h0000_D041);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_event_bits();
        logic [31:0] v, va;
        wrr(0, 1, 32'h0);
        for (int i = 0; i < EVN; i++) begin
            pulse(0, i);
            rd(0, 0, v, va);
            chk($sformatf("R2 event %0d", i), v, 32'h1 << pos(i));
            if (i == 0) begin
                repeat (3) @(negedge clk);
                rd(0, 0, v, va);
                chk("R2 sticky", v, 32'h1);
            end
            wrr(0, 0, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_w1c();
        logic [31:0] v, va;
        pulse(0, 0); pulse(0, 4); pulse(0, 9);
        rd(0, 0, v, va); chk("R3 setup", v, 32'h0000_1081);
        wrr(0, 0, 32'h80);
        rd(0, 0, v, va); chk("R3 clear one bit", v, 32'h0000_1001);
        wrr(0, 0, 32'h38);
        rd(0, 0, v, va); chk("R3 reserved write", v, 32'h0000_1001);
        wrr(0, 0, 32'hC000);
        rd(0, 0, v, va); chk("R3 summary write", v, 32'h0000_1001);
        wrr(0, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_collision();
        logic [31:0] v, va;
        @(negedge clk);
        wr = 1'b1; addr = 3'b000; wdata = 32'h1; evt[0] = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0; evt = '0;
        rd(0, 0, v, va); chk("R4 event wins", v, 32'h1);
        wrr(0, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_summary();
        logic [31:0] v, va;
        wrr(0, 1, 32'h0000_1001);
        pulse(0, 0);
        rd(0, 0, v, va); chk("R5 normal summary", v, 32'h0000_8001);
        chk("R7 no NIE no irq", {31'b0, irq}, 32'h0);
        wrr(0, 1, 32'h0001_1001);
        #1; chk("R7 NIE irq", {31'b0, irq}, 32'h1);
        pulse(0, 1);
        rd(0, 0, v, va); chk("R6 unmasked source off", v, 32'h0000_8003);
        wrr(0, 1, 32'h0001_1003);
        rd(0, 0, v, va); chk("R6 abnormal summary", v, 32'h0000_C003);
        wrr(0, 0, 32'h1);
        rd(0, 0, v, va); chk("R5 normal drops", v, 32'h0000_4002);
        chk("R7 AIE off irq", {31'b0, irq}, 32'h0);
        wrr(0, 1, 32'h0001_9003);
        #1; chk("R7 AIE irq", {31'b0, irq}, 32'h1);
        wrr(0, 0, 32'h2);
        rd(0, 0, v, va); chk("R11 summaries cleared", v, 32'h0);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_errcode();
        logic [31:0] v, va;
        wrr(0, 1, 32'h0);
        @(negedge clk);
        txc[2:0] = 3'd5; rxc[2:0] = 3'd3; evt[9] = 1'b1;
        @(negedge clk);
        evt = '0; txc = '0; rxc = '0;
        rd(0, 0, v, va); chk("R8 codes", v, 32'h001D_1000);
        wrr(0, 0, 32'h0007_0000);
        rd(0, 0, v, va); chk("R8 tx code clear", v, 32'h0018_1000);
        wrr(0, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable_mask();
        logic [31:0] v, va;
        wrr(0, 1, 32'hFFFF_FFFF);
        rd(0, 1, v, va);
        chk("R10 layout0 mask", v, 32'h0001_BFC7);
        chk("R10 layout1 mask", va, 32'h0000_FFC7);
        wrr(0, 1, 32'h0);
    endtask

    task automatic t_top();
        logic [31:0] v, va;
        clear_all();
        pulse(1, 3);
        rd(0, 2, v, va); chk("R9 channel 1 bit", v, 32'h0000_0002);
        chk("R9 irq from ch1", {31'b0, irq}, 32'h1);
        qirq = 1'b1; mirq = 1'b1;
        rd(1, 2, v, va); chk("R9 queue and mac", v, 32'h0003_0002);
        qirq = 1'b0; mirq = 1'b0;
        clear_all();
    endtask

    task automatic t_layout();
        clear_all();
        wrr(0, 1, 32'h0001_0001);
        pulse(0, 0);
        #1;
        chk("R7 layout0 bit16 NIE", {31'b0, irq}, 32'h1);
        chk("R7 layout1 bit16 ignored", {31'b0, irq_alt}, 32'h0);
        wrr(0, 1, 32'h0000_8001);
        #1;
        chk("R7 layout0 bit15 is AIE", {31'b0, irq}, 32'h0);
        chk("R7 layout1 bit15 NIE", {31'b0, irq_alt}, 32'h1);
        clear_all();
    endtask

    task automatic t_isolation();
        logic [31:0] v, va;
        wrr(0, 1, 32'h0);
        pulse(0, 4);
        rd(1, 0, v, va); chk("R12 ch1 untouched", v, 32'h0);
        wrr(1, 0, 32'hFFFF_FFFF);
        rd(0, 0, v, va); chk("R12 ch0 kept", v, 32'h0000_0080);
        rd(0, 3, v, va); chk("R12 select 3 zero", v, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_bits();
        t_w1c();
        t_collision();
        t_summary();
        t_errcode();
        t_enable_mask();
        t_top();
        t_layout();
        t_isolation();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule